// File: doc/BRIEF.md
# Heartbeat Alert and Lockup Recovery Controller

This block decides when a platform-management link should emit an alert message, and which kind. While the platform sleeps, is switched off, or is locked up, it requests a heartbeat message on a fixed tick-based period. When a hardware event arrives and the platform has not shut down, it requests an event message straight away. Every message carries an 8-bit sequence number that advances by one per message. A downstream serializer turns each request into bits and acknowledges it with a done pulse. Bit-level serialization is outside this block.

The block also follows the recovery path after a watchdog second-timeout. It watches for an override press followed by a wake press, or for a power-OK-low pulse or a management-bus reset message. It turns each of these into a single reboot or reset request pulse. It then waits a bounded number of ticks for firmware to clear the timeout status. If that window runs out, the attempt is treated as failed: no further automatic reboot or reset is requested until the block itself is reset. Heartbeats keep flowing in that case.

Top module: `hb_alert_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `msg_req_o`, `reboot_req_o` and `reset_req_o` are 0. The first message after reset carries sequence number 1.
- R2: Power-state code 2'b01 means sleeping. In that state, `msg_req_o` rises with `msg_type_o`=0 (heartbeat) on the cycle after the HB_PERIOD-th tick counted since the last completed message. It stays low after fewer ticks.
- R3: Power-state code 2'b00 means working. In that state, with `second_to_i` low and no failed recovery, ticks and hardware events raise no request.
- R4: In the sleeping state, a pulse on any `hw_evt_i` bit raises `msg_req_o` with `msg_type_o`=1 on the next cycle. If a message is already in flight, the event message starts one cycle after the in-flight request drops.
- R5: Each new request carries the previous sequence number plus one, modulo 256. Type and sequence number hold steady while `msg_req_o` stays high until `msg_done_i`.
- R6: Ticks that arrive while a request is pending are not counted. The heartbeat period restarts from zero after every completed message.
- R7: A request already raised stays high until `msg_done_i`, even when the power state changes to working.
- R8: In the working state with `second_to_i` high, heartbeats are sent every HB_PERIOD ticks. After `second_to_i` is cleared, they stop, provided recovery did not fail.
- R9: After a timeout, `pwrok_low_i` or `smb_rst_i` gives one single-cycle `reset_req_o` pulse. `pwrbtn_ovr_i` followed by `pwrbtn_i` gives one single-cycle `reboot_req_o` pulse. `pwrbtn_i` alone, without a prior override, gives none.
- R10: If `second_to_i` is still high FAIL_TICKS ticks after an attempt, all later button, power-OK and reset-message pulses give no reboot or reset pulse. Heartbeats continue even after the status clears. Only `rst` re-arms recovery.
- R11: If `second_to_i` clears inside the window, recovery re-arms, and a later timeout can again produce a reboot or reset request.
- R12: Power-state codes 2'b10 and 2'b11 mean soft-off. In soft-off, heartbeats are sent on the period, and hardware events raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the external intervention that re-arms recovery |
| pwr_state_i | input | 2 | Power state: 00 working, 01 sleeping, 10/11 soft-off |
| tick_i | input | 1 | One-second tick, one cycle wide |
| hw_evt_i | input | EVT_W | Hardware event pulses |
| second_to_i | input | 1 | Watchdog second-timeout status, cleared by software |
| pwrbtn_i | input | 1 | Power-button press pulse |
| pwrbtn_ovr_i | input | 1 | Power-button override pulse |
| pwrok_low_i | input | 1 | Power-OK-low pulse |
| smb_rst_i | input | 1 | Reset message received over the management bus |
| msg_done_i | input | 1 | Serializer finished the current message |
| msg_req_o | output | 1 | Message request, held until done |
| msg_type_o | output | 1 | 0 heartbeat, 1 event |
| msg_seq_o | output | SEQ_W | Sequence number of the current message |
| reboot_req_o | output | 1 | Single-cycle reboot request |
| reset_req_o | output | 1 | Single-cycle reset request |

## Verification
The assertions assume that `msg_done_i` arrives only while a request is pending. They also assume that tick, event and button inputs are single-cycle pulses, and that HB_PERIOD is at least 2. The stimulus pulses every one of these inputs for exactly one cycle and raises done only after it has seen the request. Button pulses are applied at least one cycle after `second_to_i` rises, so the recovery tracker has already registered the lockup.

// File: rtl/hb_alert_pkg.sv
package hb_alert_pkg;

    typedef enum logic [1:0] {
        PWR_WORK  = 2'b00,
        PWR_SLEEP = 2'b01,
        PWR_OFF   = 2'b10,
        PWR_RSVD  = 2'b11
    } pwr_state_e;

    typedef enum logic {
        MSG_HB  = 1'b0,
        MSG_EVT = 1'b1
    } msg_kind_e;

    typedef enum logic [2:0] {
        REC_IDLE,
        REC_LOCK,
        REC_OFF,
        REC_WAIT,
        REC_FAILED
    } rec_state_e;

    // Heartbeats run when not working, or while locked up, or after failed recovery.
    function automatic logic hb_enabled(pwr_state_e p, logic lock, logic failed);
        return (p != PWR_WORK) || lock || failed;
    endfunction

    // Events are reported only before shutdown, and only when the schedule is live.
    function automatic logic evt_allowed(pwr_state_e p, logic hb_en);
        return hb_en && ((p == PWR_SLEEP) || (p == PWR_WORK));
    endfunction

endpackage

// File: rtl/hb_sched.sv
module hb_sched #(
    parameter int unsigned HB_PERIOD = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic evt_ok_i,
    input  logic evt_now_i,
    input  logic tick_i,
    input  logic busy_i,
    input  logic done_i,
    input  logic launch_evt_i,
    output logic evt_due_o,
    output logic hb_due_o
);
    localparam int unsigned CNT_W = $clog2(HB_PERIOD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             last_tick;

    assign last_tick = (cnt_q == CNT_W'(HB_PERIOD - 1));
    assign hb_due_o  = active_i && !busy_i && tick_i && last_tick;
    assign evt_due_o = evt_ok_i && (pend_q || evt_now_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (done_i || !active_i) begin
            cnt_q <= '0;
        end else if (!busy_i && tick_i) begin
            cnt_q <= last_tick ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (!evt_ok_i || launch_evt_i) begin
            pend_q <= 1'b0;
        end else if (evt_now_i) begin
            pend_q <= 1'b1;
        end
    end

    // R4: an event held back behind a message is not lost while still allowed
    p_pend_kept_r4: assert property (@(posedge clk) disable iff (rst)
        pend_q && evt_ok_i && !launch_evt_i |=> pend_q);

    // R6: ticks arriving during an in-flight message are not counted
    p_count_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        busy_i && !done_i && active_i |=> $stable(cnt_q));

endmodule

// File: rtl/hb_msg_seq.sv
module hb_msg_seq
    import hb_alert_pkg::*;
#(
    parameter int unsigned SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_due_i,
    input  logic             hb_due_i,
    input  logic             done_i,
    output logic             busy_o,
    output msg_kind_e        kind_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic             launch_evt_o
);
    logic             busy_q;
    msg_kind_e        kind_q;
    logic [SEQ_W-1:0] seq_q;
    logic             launch;

    assign launch_evt_o = !busy_q && evt_due_i;
    assign launch       = launch_evt_o || (!busy_q && hb_due_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= MSG_HB;
            seq_q  <= '0;
        end else if (busy_q && done_i) begin
            busy_q <= 1'b0;
        end else if (launch) begin
            busy_q <= 1'b1;
            kind_q <= launch_evt_o ? MSG_EVT : MSG_HB;
            seq_q  <= seq_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign kind_o = kind_q;
    assign seq_o  = seq_q;

    // R5: descriptor is frozen while the serializer works on it
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy_q && !done_i |=> busy_q && $stable(seq_q) && $stable(kind_q));

    // R5: each new message advances the number by exactly one
    p_seq_step_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> seq_q == SEQ_W'($past(seq_q) + 1'b1));

    // R4: a due event wins over a heartbeat when idle
    p_evt_first_r4: assert property (@(posedge clk) disable iff (rst)
        !busy_q && evt_due_i |=> busy_q && kind_q == MSG_EVT);

endmodule

// File: rtl/hb_rec_fsm.sv
module hb_rec_fsm
    import hb_alert_pkg::*;
#(
    parameter int unsigned FAIL_TICKS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic ovr_i,
    input  logic wake_i,
    input  logic rst_try_i,
    input  logic tick_i,
    output logic reboot_o,
    output logic reset_o,
    output logic failed_o
);
    localparam int unsigned WCNT_W = $clog2(FAIL_TICKS + 1);

    rec_state_e        state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q;
    logic              reboot_q, reset_q;
    logic              reboot_d, reset_d;
    logic              window_end;

    assign window_end = tick_i && (wcnt_q == WCNT_W'(FAIL_TICKS - 1));

    always_comb begin
        state_d  = state_q;
        reboot_d = 1'b0;
        reset_d  = 1'b0;
        case (state_q)
            REC_IDLE: begin
                if (lock_i) state_d = REC_LOCK;
            end
            REC_LOCK: begin
                if (!lock_i) begin
                    state_d = REC_IDLE;
                end else if (rst_try_i) begin
                    reset_d = 1'b1;
                    state_d = REC_WAIT;
                end else if (ovr_i) begin
                    state_d = REC_OFF;
                end
            end
            REC_OFF: begin
                if (!lock_i) begin
                    state_d = REC_IDLE;
                end else if (rst_try_i) begin
                    reset_d = 1'b1;
                    state_d = REC_WAIT;
                end else if (wake_i) begin
                    reboot_d = 1'b1;
                    state_d  = REC_WAIT;
                end
            end
            REC_WAIT: begin
                if (!lock_i) begin
                    state_d = REC_IDLE;
                end else if (window_end) begin
                    state_d = REC_FAILED;
                end
            end
            REC_FAILED: state_d = REC_FAILED;
            default:    state_d = REC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= REC_IDLE;
            reboot_q <= 1'b0;
            reset_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            reboot_q <= reboot_d;
            reset_q  <= reset_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != REC_WAIT) begin
            wcnt_q <= '0;
        end else if (tick_i) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assign reboot_o = reboot_q;
    assign reset_o  = reset_q;
    assign failed_o = (state_q == REC_FAILED);

    // R9: never both requests at once, and each lasts one cycle
    p_single_req_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reboot_q, reset_q}));
    p_pulse_short_r9: assert property (@(posedge clk) disable iff (rst)
        (reboot_q || reset_q) |=> !(reboot_q || reset_q));
    // R9: an attempt only follows a recorded lockup
    p_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (reboot_q || reset_q) |-> $past(lock_i));

    // R10: failure is sticky and silent
    p_failed_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        state_q == REC_FAILED |=> state_q == REC_FAILED);
    p_failed_silent_r10: assert property (@(posedge clk) disable iff (rst)
        $past(state_q == REC_FAILED) |-> !reboot_q && !reset_q);

endmodule

// File: rtl/hb_alert_ctrl.sv
module hb_alert_ctrl
    import hb_alert_pkg::*;
#(
    parameter int unsigned HB_PERIOD  = 31,
    parameter int unsigned FAIL_TICKS = 60,
    parameter int unsigned EVT_W      = 4,
    parameter int unsigned SEQ_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pwr_state_i,
    input  logic             tick_i,
    input  logic [EVT_W-1:0] hw_evt_i,
    input  logic             second_to_i,
    input  logic             pwrbtn_i,
    input  logic             pwrbtn_ovr_i,
    input  logic             pwrok_low_i,
    input  logic             smb_rst_i,
    input  logic             msg_done_i,
    output logic             msg_req_o,
    output logic             msg_type_o,
    output logic [SEQ_W-1:0] msg_seq_o,
    output logic             reboot_req_o,
    output logic             reset_req_o
);
    pwr_state_e pwr;
    logic       failed, hb_active, evt_ok;
    logic       evt_due, hb_due, launch_evt, busy;
    msg_kind_e  kind;

    assign pwr       = pwr_state_e'(pwr_state_i);
    assign hb_active = hb_enabled(pwr, second_to_i, failed);
    assign evt_ok    = evt_allowed(pwr, hb_active);

    hb_rec_fsm #(.FAIL_TICKS(FAIL_TICKS)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (second_to_i),
        .ovr_i     (pwrbtn_ovr_i),
        .wake_i    (pwrbtn_i),
        .rst_try_i (pwrok_low_i || smb_rst_i),
        .tick_i    (tick_i),
        .reboot_o  (reboot_req_o),
        .reset_o   (reset_req_o),
        .failed_o  (failed)
    );

    hb_sched #(.HB_PERIOD(HB_PERIOD)) u_sched (
        .clk          (clk),
        .rst          (rst),
        .active_i     (hb_active),
        .evt_ok_i     (evt_ok),
        .evt_now_i    (|hw_evt_i),
        .tick_i       (tick_i),
        .busy_i       (busy),
        .done_i       (msg_done_i && busy),
        .launch_evt_i (launch_evt),
        .evt_due_o    (evt_due),
        .hb_due_o     (hb_due)
    );

    hb_msg_seq #(.SEQ_W(SEQ_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .evt_due_i    (evt_due),
        .hb_due_i     (hb_due),
        .done_i       (msg_done_i),
        .busy_o       (busy),
        .kind_o       (kind),
        .seq_o        (msg_seq_o),
        .launch_evt_o (launch_evt)
    );

    assign msg_req_o  = busy;
    assign msg_type_o = (kind == MSG_EVT);

    // R3: a quiet, healthy working platform stays quiet
    p_quiet_working_r3: assert property (@(posedge clk) disable iff (rst)
        !msg_req_o && pwr == PWR_WORK && !second_to_i && !failed |=> !msg_req_o);

    // R7: a raised request is never withdrawn without done
    p_no_abort_r7: assert property (@(posedge clk) disable iff (rst)
        msg_req_o && !msg_done_i |=> msg_req_o);

endmodule

// File: tb/hb_alert_ctrl_tb.sv
module hb_alert_ctrl_tb;
    localparam int unsigned P  = 4;
    localparam int unsigned FT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pwr_state = 2'b01;
    logic       tick = 1'b0;
    logic [1:0] hw_evt = 2'b00;
    logic       second_to = 1'b0;
    logic       pwrbtn = 1'b0, pwrbtn_ovr = 1'b0, pwrok_low = 1'b0, smb_rst = 1'b0;
    logic       msg_done = 1'b0;
    logic       msg_req, msg_type, reboot_req, reset_req;
    logic [7:0] msg_seq;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_seq = 8'd0;

    always #10 clk = ~clk;

    hb_alert_ctrl #(.HB_PERIOD(P), .FAIL_TICKS(FT), .EVT_W(2), .SEQ_W(8)) u_dut (
        .clk(clk), .rst(rst), .pwr_state_i(pwr_state), .tick_i(tick), .hw_evt_i(hw_evt),
        .second_to_i(second_to), .pwrbtn_i(pwrbtn), .pwrbtn_ovr_i(pwrbtn_ovr),
        .pwrok_low_i(pwrok_low), .smb_rst_i(smb_rst), .msg_done_i(msg_done),
        .msg_req_o(msg_req), .msg_type_o(msg_type), .msg_seq_o(msg_seq),
        .reboot_req_o(reboot_req), .reset_req_o(reset_req)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc(); tick = 1'b0;
    endtask

    task automatic do_evt();
        hw_evt = 2'b10; cyc(); hw_evt = 2'b00;
    endtask

    task automatic do_done();
        msg_done = 1'b1; cyc(); msg_done = 1'b0;
    endtask

    task automatic expect_msg(input string tag, input int typ);
        exp_seq = exp_seq + 8'd1;
        chk({tag, " req"}, int'(msg_req), 1);
        chk({tag, " type"}, int'(msg_type), typ);
        chk({tag, " seq"}, int'(msg_seq), int'(exp_seq));
    endtask

    // P-1 ticks with no request, then the P-th raises a heartbeat
    task automatic hb_period(input string tag);
        for (int i = 0; i < P - 1; i++) begin
            do_tick();
            chk({tag, " early"}, int'(msg_req), 0);
        end
        do_tick();
        expect_msg(tag, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        chk("R1 reset req", int'(msg_req), 0);
        chk("R1 reset reboot", int'(reboot_req), 0);
        rst = 1'b0;
        cyc();
        chk("R1 after reset req", int'(msg_req), 0);
        chk("R1 after reset resetreq", int'(reset_req), 0);

        // R2 sleeping heartbeat; R1 first seq is 1
        hb_period("R2 sleep hb");
        for (int i = 0; i < 3; i++) begin
            do_tick();
            chk("R5 hold req", int'(msg_req), 1);
            chk("R5 hold seq", int'(msg_seq), int'(exp_seq));
        end
        do_done();
        chk("R5 done drops req", int'(msg_req), 0);
        hb_period("R6 restart after done");
        do_done();

        // R4 event mid-period, then R6 restart
        do_tick(); do_tick();
        do_evt();
        expect_msg("R4 event", 1);
        do_done();
        hb_period("R6 restart after event");
        do_evt();
        chk("R4 event while busy type", int'(msg_type), 0);
        do_done();
        chk("R4 gap cycle", int'(msg_req), 0);
        cyc();
        expect_msg("R4 deferred event", 1);
        do_done();

        // R5 wrap sweep
        for (int i = 0; i < 256; i++) begin
            do_evt();
            exp_seq = exp_seq + 8'd1;
            chk("R5 sweep seq", int'(msg_seq), int'(exp_seq));
            do_done();
        end

        // R3 working, healthy
        pwr_state = 2'b00;
        for (int i = 0; i < 2 * P; i++) begin
            do_tick();
            do_evt();
            chk("R3 working quiet", int'(msg_req), 0);
        end

        // R7 message finishes across entry to working
        pwr_state = 2'b01;
        cyc();
        hb_period("R7 start");
        pwr_state = 2'b00;
        repeat (3) begin
            cyc();
            chk("R7 kept", int'(msg_req), 1);
        end
        do_done();
        chk("R7 ends on done", int'(msg_req), 0);

        // R8 lockup in working, R9 reset attempt, R11 success
        second_to = 1'b1;
        cyc();
        hb_period("R8 lockup hb");
        do_done();
        pwrbtn = 1'b1; cyc(); pwrbtn = 1'b0;
        chk("R9 press without override", int'(reboot_req), 0);
        pwrok_low = 1'b1; cyc(); pwrok_low = 1'b0;
        chk("R9 reset pulse", int'(reset_req), 1);
        cyc();
        chk("R9 reset single", int'(reset_req), 0);
        do_tick();
        second_to = 1'b0;
        cyc();
        for (int i = 0; i < 2 * P; i++) begin
            do_tick();
            chk("R8 stop after clear", int'(msg_req), 0);
        end

        // R11 re-armed: override then press, R10 failure
        second_to = 1'b1;
        cyc();
        pwrbtn_ovr = 1'b1; cyc(); pwrbtn_ovr = 1'b0;
        chk("R9 override alone", int'(reboot_req), 0);
        pwrbtn = 1'b1; cyc(); pwrbtn = 1'b0;
        chk("R11 reboot pulse", int'(reboot_req), 1);
        cyc();
        chk("R9 reboot single", int'(reboot_req), 0);
        hb_period("R10 hb during window");
        do_done();
        pwrbtn_ovr = 1'b1; cyc(); pwrbtn_ovr = 1'b0;
        pwrbtn = 1'b1; cyc(); pwrbtn = 1'b0;
        chk("R10 no reboot", int'(reboot_req), 0);
        pwrok_low = 1'b1; cyc(); pwrok_low = 1'b0;
        chk("R10 no reset pwrok", int'(reset_req), 0);
        smb_rst = 1'b1; cyc(); smb_rst = 1'b0;
        chk("R10 no reset smb", int'(reset_req), 0);
        second_to = 1'b0;
        cyc();
        hb_period("R10 hb after failure");
        do_done();

        // R10 re-arm by rst; R1 sequence restarts
        rst = 1'b1; repeat (2) cyc(); rst = 1'b0;
        exp_seq = 8'd0;
        second_to = 1'b1;
        cyc();
        smb_rst = 1'b1; cyc(); smb_rst = 1'b0;
        chk("R10 rearmed by rst", int'(reset_req), 1);
        hb_period("R1 seq after reset");
        do_done();
        rst = 1'b1; second_to = 1'b0; repeat (2) cyc(); rst = 1'b0;
        exp_seq = 8'd0;

        // R12 soft-off
        pwr_state = 2'b10;
        cyc();
        do_evt();
        chk("R12 event ignored", int'(msg_req), 0);
        cyc();
        chk("R12 event ignored later", int'(msg_req), 0);
        hb_period("R12 soft-off hb");
        do_done();
        pwr_state = 2'b11;
        hb_period("R12 code 3 hb");
        do_done();

        finish_run();
    end
endmodule